// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog counter driven by the system clock. After a period picked by a two-bit select input, it sets a sticky time-out flag. When the reset function is enabled it then waits a fixed grace window and emits a one-cycle system reset pulse. The pulse also sets a sticky reset-cause flag, so software can tell after the restart why the chip was reset.

Software keeps the watchdog quiet by pulsing the restart strobe before the period ends. That strobe is modelled as a single-cycle input, because the hardware clears it by itself. Software clears the two flags with separate write strobes. The interrupt request seen by the CPU is the time-out flag gated by the interrupt-enable input. The flag itself is set whether or not the interrupt is enabled, so with the interrupt off it only records that the period ran out.

`rst_n` stands for the power-fail / power-on reset. It is the only event other than a software clear that empties the reset-cause flag. All pins are plain control and status lines. There is no data stream, so no valid/ready handshake applies.

Top module: `wdog_two_stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `irq_flag`, `irq_req`, `rst_flag` and `sys_rst` are all 0.
- R2: `irq_flag` becomes 1 exactly T(sel) clock edges after the edge that restarts the count. T(sel) = 2^(BASE_SHIFT + SHIFT_STEP*sel), with `period_sel` read as an unsigned value 0..3. The defaults give 2^17, 2^20, 2^23 and 2^26 clocks.
- R3: `irq_flag` is set at time-out whatever the value of `irq_en`, and `irq_req` always equals `irq_flag & irq_en`.
- R4: With `rst_en` = 1, `sys_rst` is high for exactly one cycle, T(sel) + GRACE edges after the restart edge. That is GRACE (default 512) edges after `irq_flag` was set. The pulse sets `rst_flag`, and the count starts again from zero, so the next pulse follows after another T(sel) + GRACE edges.
- R5: With `rst_en` = 0, no `sys_rst` pulse is ever produced and `rst_flag` is left unchanged.
- R6: A one-cycle `restart` pulse sets the count back to zero. If it arrives on the edge where a time-out would fire, the restart wins and no flag is set.
- R7: Any change of `period_sel` restarts the count in the same way as `restart`. A count already past the new, shorter period therefore does not trip it at once.
- R8: `irq_flag` and `rst_flag` stay set until the matching clear strobe (`clr_irq_flag`, `clr_rst_flag`) is seen. If a set and a clear fall on the same edge, the set wins.
- R9: Driving `rst_n` low clears `rst_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the count advances on every rising edge |
| rst_n | input | 1 | Active-low power-fail / power-on reset |
| period_sel | input | 2 | Time-out period select; any change restarts the count |
| rst_en | input | 1 | Enables the reset stage after the grace window |
| irq_en | input | 1 | Gates the interrupt request output |
| restart | input | 1 | One-cycle strobe that restarts the count |
| clr_irq_flag | input | 1 | Software write strobe clearing the time-out flag |
| clr_rst_flag | input | 1 | Software write strobe clearing the reset-cause flag |
| irq_flag | output | 1 | Sticky time-out flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| rst_flag | output | 1 | Sticky flag recording a watchdog-caused reset |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
The main function is exercised with every period select, each paired with reset enabled and disabled and with the interrupt enabled and disabled. This separates the four period lengths, the presence or absence of the reset stage, and the interrupt gating from the flag itself. Directed patterns then cover:
- a restart in the middle of a period, which must push the time-out out by a full period;
- a restart on the exact time-out edge, which must suppress the flag;
- a switch from the longest to the shortest period after a long wait, which must not fire early;
- a flag clear on the set edge, which must lose to the set;
- two back-to-back reset pulses, which show that the count returns to zero;
- a power-fail reset, which must empty the reset-cause flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Number of period choices selected by the two-bit input
  localparam int NUM_PERIODS = 4;

  // Shift amount for a given period select
  function automatic int period_shift(input int base_shift, input int step,
                                      input logic [1:0] sel);
    return base_shift + step * int'(sel);
  endfunction

endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
  parameter int BASE_SHIFT = 17,
  parameter int SHIFT_STEP = 3,
  parameter int GRACE      = 512,
  parameter int CNT_W      = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       period_sel,
  output logic             sel_changed,
  output logic [CNT_W-1:0] irq_last,   // count value on the edge the flag sets
  output logic [CNT_W-1:0] end_last    // count value on the edge the reset fires
);
  import wdt_pkg::*;

  logic [1:0]       sel_q;
  logic [CNT_W-1:0] period_len [NUM_PERIODS];

  // One terminal length per select value
  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_len
    assign period_len[g] = {{(CNT_W-1){1'b0}}, 1'b1}
                           << period_shift(BASE_SHIFT, SHIFT_STEP, 2'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 2'd0;
    else        sel_q <= period_sel;
  end

  assign sel_changed = (period_sel != sel_q);
  assign irq_last    = period_len[sel_q] - CNT_W'(1);
  assign end_last    = period_len[sel_q] + CNT_W'(GRACE) - CNT_W'(1);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] irq_last,
  input  logic [CNT_W-1:0] end_last,
  output logic             hit_irq,
  output logic             hit_end
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (hit_end) cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  assign hit_irq = (cnt_q == irq_last);
  assign hit_end = (cnt_q == end_last);

  // R4: the count never runs past the end of the reset window
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= end_last);

  // R6: a clear request leaves the count at the start of a period
  a_r6_clear_hits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hit_irq,
  input  logic hit_end,
  input  logic rst_en,
  input  logic clr_irq_flag,
  input  logic clr_rst_flag,
  output logic irq_flag,
  output logic rst_flag,
  output logic sys_rst
);
  logic set_irq;
  logic fire_rst;

  // A restart or period change beats any terminal hit on the same edge
  assign set_irq  = hit_irq & ~clear;
  assign fire_rst = hit_end & rst_en & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      rst_flag <= 1'b0;
      sys_rst  <= 1'b0;
    end else begin
      sys_rst <= fire_rst;
      if (set_irq)           irq_flag <= 1'b1;
      else if (clr_irq_flag) irq_flag <= 1'b0;
      if (fire_rst)          rst_flag <= 1'b1;
      else if (clr_rst_flag) rst_flag <= 1'b0;
    end
  end

  // R4: the reset output is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  // R4: the reset-cause flag only rises together with a reset pulse
  a_r4_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_flag) |-> sys_rst);

  // R5: no pulse unless reset was enabled on the firing edge
  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past(rst_en));

  // R8: flags hold until their clear strobe
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_irq_flag) |=> irq_flag);

  a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_flag && !clr_rst_flag) |=> rst_flag);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int BASE_SHIFT = 17,
  parameter int SHIFT_STEP = 3,
  parameter int GRACE      = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] period_sel,
  input  logic       rst_en,
  input  logic       irq_en,
  input  logic       restart,
  input  logic       clr_irq_flag,
  input  logic       clr_rst_flag,
  output logic       irq_flag,
  output logic       irq_req,
  output logic       rst_flag,
  output logic       sys_rst
);
  localparam int MAX_SHIFT = BASE_SHIFT + SHIFT_STEP * (wdt_pkg::NUM_PERIODS - 1);
  localparam longint MAX_END = (longint'(1) << MAX_SHIFT) + longint'(GRACE);
  localparam int CNT_W = $clog2(MAX_END + 1);

  logic             sel_changed;
  logic             clear;
  logic             hit_irq;
  logic             hit_end;
  logic [CNT_W-1:0] irq_last;
  logic [CNT_W-1:0] end_last;

  wdt_period_sel #(
    .BASE_SHIFT(BASE_SHIFT),
    .SHIFT_STEP(SHIFT_STEP),
    .GRACE     (GRACE),
    .CNT_W     (CNT_W)
  ) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_sel (period_sel),
    .sel_changed(sel_changed),
    .irq_last   (irq_last),
    .end_last   (end_last)
  );

  assign clear = restart | sel_changed;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .irq_last(irq_last),
    .end_last(end_last),
    .hit_irq (hit_irq),
    .hit_end (hit_end)
  );

  wdt_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .hit_irq     (hit_irq),
    .hit_end     (hit_end),
    .rst_en      (rst_en),
    .clr_irq_flag(clr_irq_flag),
    .clr_rst_flag(clr_rst_flag),
    .irq_flag    (irq_flag),
    .rst_flag    (rst_flag),
    .sys_rst     (sys_rst)
  );

  assign irq_req = irq_flag & irq_en;

  // R6: a restart request never lets the next cycle carry a reset pulse
  a_r6_restart_blocks_reset: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sys_rst);

  // R7: a period change never lets the flag rise on the following edge
  a_r7_change_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_changed && !irq_flag) |=> !irq_flag);

endmodule

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE  = 4;
  localparam int STEP  = 2;
  localparam int GR    = 8;
  localparam int NVEC  = 6;
  // each entry: {period_sel[1:0], rst_en, irq_en}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b00_1_1, 4'b01_0_1, 4'b10_1_0, 4'b11_1_1, 4'b00_0_0, 4'b11_0_1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] period_sel = 2'd0;
  logic rst_en = 1'b0, irq_en = 1'b0, restart = 1'b0;
  logic clr_irq_flag = 1'b0, clr_rst_flag = 1'b0;
  logic irq_flag, irq_req, rst_flag, sys_rst;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_two_stage #(.BASE_SHIFT(BASE), .SHIFT_STEP(STEP), .GRACE(GR)) u_wdog_two_stage (
    .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .rst_en(rst_en),
    .irq_en(irq_en), .restart(restart), .clr_irq_flag(clr_irq_flag),
    .clr_rst_flag(clr_rst_flag), .irq_flag(irq_flag), .irq_req(irq_req),
    .rst_flag(rst_flag), .sys_rst(sys_rst)
  );

  function automatic int tlen(input logic [1:0] s);
    return 1 << (BASE + STEP * int'(s));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse restart with both clears; returns just after the restart edge
  task automatic restart_pulse();
    @(negedge clk); restart = 1'b1; clr_irq_flag = 1'b1; clr_rst_flag = 1'b1;
    @(negedge clk); restart = 1'b0; clr_irq_flag = 1'b0; clr_rst_flag = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check({irq_flag, irq_req, rst_flag, sys_rst} == 4'b0, "R1 in reset",
          int'({irq_flag, irq_req, rst_flag, sys_rst}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({irq_flag, irq_req, rst_flag, sys_rst} == 4'b0, "R1 after release",
          int'({irq_flag, irq_req, rst_flag, sys_rst}), 0);

    // Vector table: R2 period, R3 gating, R4 pulse, R5 disabled reset
    for (int v = 0; v < NVEC; v++) begin
      int t, first_irq, npulse, pulse_at;
      bit req_ok;
      period_sel = VEC[v][3:2]; rst_en = VEC[v][1]; irq_en = VEC[v][0];
      t = tlen(VEC[v][3:2]);
      restart_pulse();
      first_irq = -1; npulse = 0; pulse_at = -1; req_ok = 1'b1;
      for (int j = 1; j <= t + GR + 4; j++) begin
        @(negedge clk);
        if (irq_flag && first_irq < 0) first_irq = j;
        if (sys_rst) begin npulse++; pulse_at = j; end
        if (irq_req != (irq_flag & irq_en)) req_ok = 1'b0;
      end
      check(first_irq == t, "R2 period length", first_irq, t);
      check(req_ok, "R3 irq_req gating", int'(req_ok), 1);
      if (rst_en) begin
        check(npulse == 1 && pulse_at == t + GR, "R4 pulse timing", pulse_at, t + GR);
        check(rst_flag == 1'b1, "R4 rst_flag set", int'(rst_flag), 1);
      end else begin
        check(npulse == 0, "R5 no pulse", npulse, 0);
        check(rst_flag == 1'b0, "R5 rst_flag unchanged", int'(rst_flag), 0);
      end
    end

    // R5: rst_flag already set is left set with reset disabled
    period_sel = 2'd0; rst_en = 1'b1; irq_en = 1'b1;
    restart_pulse();
    repeat (tlen(2'd0) + GR + 1) @(negedge clk);
    rst_en = 1'b0;
    repeat (tlen(2'd0) + GR + 2) @(negedge clk);
    check(rst_flag == 1'b1, "R5 flag kept when disabled", int'(rst_flag), 1);

    // R4: counter returns to zero after pulse -> second pulse at 2*(T+G)
    begin
      int n2, second_at;
      rst_en = 1'b1;
      restart_pulse();
      n2 = 0; second_at = -1;
      for (int j = 1; j <= 2 * (tlen(2'd0) + GR) + 2; j++) begin
        @(negedge clk);
        if (sys_rst) begin n2++; second_at = j; end
      end
      check(n2 == 2 && second_at == 2 * (tlen(2'd0) + GR), "R4 second pulse",
            second_at, 2 * (tlen(2'd0) + GR));
    end
    rst_en = 1'b0;

    // R6: restart mid-period pushes time-out out by a full period
    restart_pulse();
    repeat (10) @(negedge clk);
    restart_pulse();
    repeat (tlen(2'd0) - 1) @(negedge clk);
    check(irq_flag == 1'b0, "R6 no early flag", int'(irq_flag), 0);
    @(negedge clk);
    check(irq_flag == 1'b1, "R6 flag after full period", int'(irq_flag), 1);

    // R6: restart on the time-out edge wins
    restart_pulse();
    repeat (tlen(2'd0) - 2) @(negedge clk);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    check(irq_flag == 1'b0, "R6 restart beats time-out", int'(irq_flag), 0);

    // R7: switching to the short period restarts the count
    period_sel = 2'd3;
    restart_pulse();
    repeat (100) @(negedge clk);
    period_sel = 2'd0;
    @(negedge clk);
    repeat (tlen(2'd0) - 1) @(negedge clk);
    check(irq_flag == 1'b0, "R7 stale count ignored", int'(irq_flag), 0);
    @(negedge clk);
    check(irq_flag == 1'b1, "R7 new period used", int'(irq_flag), 1);

    // R8: sticky flag, then software clear
    repeat (5) @(negedge clk);
    check(irq_flag == 1'b1, "R8 flag sticky", int'(irq_flag), 1);
    clr_irq_flag = 1'b1; @(negedge clk); clr_irq_flag = 1'b0;
    check(irq_flag == 1'b0, "R8 clear strobe", int'(irq_flag), 0);

    // R8: set wins over a clear on the same edge
    restart_pulse();
    repeat (tlen(2'd0) - 1) @(negedge clk);
    clr_irq_flag = 1'b1; @(negedge clk); clr_irq_flag = 1'b0;
    check(irq_flag == 1'b1, "R8 set beats clear", int'(irq_flag), 1);

    // R9: power-fail reset clears the reset-cause flag
    rst_en = 1'b1;
    restart_pulse();
    repeat (tlen(2'd0) + GR + 1) @(negedge clk);
    check(rst_flag == 1'b1, "R9 flag set before reset", int'(rst_flag), 1);
    rst_n = 1'b0; @(negedge clk);
    check(rst_flag == 1'b0, "R9 cleared by rst_n", int'(rst_flag), 0);
    rst_n = 1'b1; @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule